// File: doc/BRIEF.md
# Multi-Edge Compare PWM Output Stage

This block turns an up-counting time base into two PWM pins that can each switch several times within one period. Eight compare lanes are supplied from an external register set. Lanes 0 to 3 serve pin A and lanes 4 to 7 serve pin B. Each pin works through its lanes in ascending lane order. While the counter sweeps upward it waits for the current lane's value, applies that lane's 2-bit action to the pin, and then moves to the next lane. When the last enabled lane has fired, the pin holds until the period-start strobe rewinds the sequence.

A count input per pin sets how many of its lanes take part. Software must program lane values that rise strictly within each pin's group. The hardware does not check spacing or order: a lane whose value the counter has already passed simply stalls that pin's sequence until the next period start. The register set is expected to stay constant during a period, which is the normal result of a shadow loader that updates on counter zero.

Top module: `multi_edge_pwm`

## Requirements
- R1: While rst_n is low, and after its release until the first action fires, pwm_a and pwm_b are 0.
- R2: Lane k occupies cmp_lanes[k*CW +: CW]. Lanes 0..3 act on pwm_a with codes act_cfg_a[2j+1:2j] for lane j. Lanes 4..7 act on pwm_b with codes act_cfg_b[2j+1:2j] for lane 4+j.
- R3: Action codes are 2'b00 no change, 2'b01 drive 0, 2'b10 drive 1 and 2'b11 invert. The pin takes its new value at the rising clock edge that ends the cycle in which tbase_cnt equals the current lane's value.
- R4: Within one period each pin consumes its enabled lanes strictly in lane order, with one lane per match, so that up to four edges per pin fall in one period.
- R5: After the last enabled lane of a pin has fired, that pin does not change again in the period, even when the counter later equals the value of a disabled lane.
- R6: used_a/used_b give the number of enabled lanes. A value of 0 freezes the pin, and values 5 to 7 act as 4.
- R7: A cycle with tbase_zero high rewinds both pins to their first lane and fires no action, even when tbase_cnt equals the current lane value in that cycle.
- R8: A lane whose value is not above the previous fired lane's value (or is 0 for the first lane) is never matched in that period, and the later lanes of that pin do not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbase_cnt | input | CW | Time-base counter value |
| tbase_zero | input | 1 | Period start strobe (counter at zero) |
| cmp_lanes | input | 2*NPER*CW | Eight packed compare values |
| act_cfg_a | input | 2*NPER | Action codes for lanes 0..3 |
| act_cfg_b | input | 2*NPER | Action codes for lanes 4..7 |
| used_a | input | $clog2(NPER+1) | Enabled lane count for pin A |
| used_b | input | $clog2(NPER+1) | Enabled lane count for pin B |
| pwm_a | output | 1 | PWM pin A |
| pwm_b | output | 1 | PWM pin B |

## Verification
The hardest cases to reach from the ports are a restart cycle in which the counter also equals the pending lane value, and a sequence that stalls part way because a lane was programmed below its predecessor. The bench can drive the counter freely, so it presents a matching counter value together with the zero strobe, and it programs one pin with a descending lane pair. For every swept counter step, a scoreboard compares both pins against a period-fold model built from the requirements.

// File: rtl/mep_pkg.sv
// Shared types for the multi-edge compare PWM stage.
// Assumes: 2-bit action codes as defined in the brief.
package mep_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_CLR  = 2'b01,
        ACT_SET  = 2'b10,
        ACT_TGL  = 2'b11
    } edge_act_e;

    // Next pin level for a given action and current level.
    function automatic logic apply_act(edge_act_e a, logic cur);
        case (a)
            ACT_CLR: apply_act = 1'b0;
            ACT_SET: apply_act = 1'b1;
            ACT_TGL: apply_act = ~cur;
            default: apply_act = cur;
        endcase
    endfunction

endpackage

// File: rtl/mep_lane_mux.sv
// Selects the compare value and action code of the lane a pin is waiting on.
// Assumes: idx is in 0..NPER; idx == NPER (sequence done) yields zeros/none.
module mep_lane_mux
    import mep_pkg::*;
#(
    parameter int CW   = 16,
    parameter int NPER = 4,
    parameter int IW   = 3
) (
    input  logic [NPER*CW-1:0] cmp_bus,
    input  logic [2*NPER-1:0]  act_bus,
    input  logic [IW-1:0]      idx,
    output logic [CW-1:0]      cur_cmp,
    output edge_act_e          cur_act
);

    // Lane selection by index.
    always_comb begin
        cur_cmp = '0;
        cur_act = ACT_NONE;
        for (int j = 0; j < NPER; j++) begin
            if (idx == IW'(j)) begin
                cur_cmp = cmp_bus[j*CW +: CW];
                cur_act = edge_act_e'(act_bus[2*j +: 2]);
            end
        end
    end

endmodule

// File: rtl/mep_edge_seq.sv
// Per-pin lane sequencer: holds the index of the pending lane, raises hit
// when the counter equals it, and rewinds on the period-start strobe.
// Assumes: lane values rise within the group; no spacing check is made.
module mep_edge_seq #(
    parameter int CW   = 16,
    parameter int NPER = 4,
    parameter int IW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tbase_cnt,
    input  logic          tbase_zero,
    input  logic [IW-1:0] used_cfg,
    input  logic [CW-1:0] cur_cmp,
    output logic [IW-1:0] idx,
    output logic          hit
);

    localparam logic [IW-1:0] MAX_USED = IW'(NPER);

    logic [IW-1:0] eff_used;
    logic          live;

    // Clamp the enabled-lane count to the lanes that exist.
    always_comb eff_used = (used_cfg > MAX_USED) ? MAX_USED : used_cfg;

    // A match counts only for a pending lane outside a restart cycle.
    always_comb begin
        live = (idx < eff_used);
        hit  = live && !tbase_zero && (tbase_cnt == cur_cmp);
    end

    // Index register: rewind at period start, step after each match.
    always_ff @(posedge clk) begin
        if (!rst_n)          idx <= '0;
        else if (tbase_zero) idx <= '0;
        else if (hit)        idx <= idx + IW'(1);
    end

endmodule

// File: rtl/mep_pin.sv
// Output flop of one PWM pin; applies the selected action on a match.
// Assumes: hit and act come from the same cycle's lane selection.
module mep_pin
    import mep_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  edge_act_e act,
    output logic      pin
);

    // Pin register: low in reset, updated only on a match.
    always_ff @(posedge clk) begin
        if (!rst_n)   pin <= 1'b0;
        else if (hit) pin <= apply_act(act, pin);
    end

endmodule

// File: rtl/multi_edge_pwm.sv
// Two-pin multi-edge PWM stage. Lanes 0..NPER-1 drive pin A and lanes
// NPER..2*NPER-1 drive pin B; each pin runs its own lane sequencer.
// Assumes: register inputs stay constant within a period.
module multi_edge_pwm
    import mep_pkg::*;
#(
    parameter int CW   = 16,
    parameter int NPER = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CW-1:0]             tbase_cnt,
    input  logic                      tbase_zero,
    input  logic [2*NPER*CW-1:0]      cmp_lanes,
    input  logic [2*NPER-1:0]         act_cfg_a,
    input  logic [2*NPER-1:0]         act_cfg_b,
    input  logic [$clog2(NPER+1)-1:0] used_a,
    input  logic [$clog2(NPER+1)-1:0] used_b,
    output logic                      pwm_a,
    output logic                      pwm_b
);

    localparam int NOUT = 2;
    localparam int IW   = $clog2(NPER + 1);
    localparam int GW   = NPER * CW;

    logic [NOUT-1:0][2*NPER-1:0] act_grp;
    logic [NOUT-1:0][IW-1:0]     used_grp;
    logic [NOUT-1:0][IW-1:0]     idx_v;
    logic [NOUT-1:0]             hit_v;
    logic [NOUT-1:0][1:0]        act_sel;
    logic [NOUT-1:0]             pin_v;

    // Group the per-pin configuration for the generate loop.
    always_comb begin
        act_grp[0]  = act_cfg_a;
        act_grp[1]  = act_cfg_b;
        used_grp[0] = used_a;
        used_grp[1] = used_b;
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_pin
        logic [CW-1:0] cur_cmp;
        edge_act_e     cur_act;

        mep_lane_mux #(.CW(CW), .NPER(NPER), .IW(IW)) u_mux (
            .cmp_bus (cmp_lanes[g*GW +: GW]),
            .act_bus (act_grp[g]),
            .idx     (idx_v[g]),
            .cur_cmp (cur_cmp),
            .cur_act (cur_act)
        );

        mep_edge_seq #(.CW(CW), .NPER(NPER), .IW(IW)) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .tbase_cnt  (tbase_cnt),
            .tbase_zero (tbase_zero),
            .used_cfg   (used_grp[g]),
            .cur_cmp    (cur_cmp),
            .idx        (idx_v[g]),
            .hit        (hit_v[g])
        );

        mep_pin u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit_v[g]),
            .act   (cur_act),
            .pin   (pin_v[g])
        );

        // Expose the selected action code for the checker.
        always_comb act_sel[g] = cur_act;
    end

    // Drive the pins.
    always_comb begin
        pwm_a = pin_v[0];
        pwm_b = pin_v[1];
    end

endmodule

// File: rtl/mep_chk.sv
// Property checker for multi_edge_pwm, attached by bind below.
module mep_chk #(
    parameter int NPER = 4,
    parameter int IW   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tbase_zero,
    input logic [IW-1:0]       used_a,
    input logic [IW-1:0]       used_b,
    input logic                pwm_a,
    input logic                pwm_b,
    input logic [1:0][IW-1:0]  idx_v,
    input logic [1:0]          hit_v,
    input logic [1:0][1:0]     act_sel
);

    // R1
    rst_low_chk: assert property (@(posedge clk) !rst_n |=> (!pwm_a && !pwm_b));

    // R3
    set_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_v[0] && act_sel[0] == 2'b10) |=> pwm_a);

    // R3
    clr_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_v[1] && act_sel[1] == 2'b01) |=> !pwm_b);

    // R3
    tgl_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_v[0] && act_sel[0] == 2'b11) |=> (pwm_a != $past(pwm_a)));

    // R4
    quiet_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_v[0] |=> $stable(pwm_a));

    // R4
    step_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tbase_zero |=> ((idx_v[0] - $past(idx_v[0])) <= IW'(1)));

    // R5
    bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_v[0] <= IW'(NPER)) && (idx_v[1] <= IW'(NPER)));

    // R6
    idle_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (used_a == '0) |=> $stable(pwm_a));

    // R6
    idle_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (used_b == '0) |=> $stable(pwm_b));

    // R7
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbase_zero |=> ($stable(pwm_a) && $stable(pwm_b)));

    // R7
    zero_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbase_zero |=> (idx_v[0] == '0 && idx_v[1] == '0));

endmodule

bind multi_edge_pwm mep_chk #(.NPER(NPER), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tbase_zero (tbase_zero),
    .used_a     (used_a),
    .used_b     (used_b),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b),
    .idx_v      (idx_v),
    .hit_v      (hit_v),
    .act_sel    (act_sel)
);

// File: tb/sim_multi_edge_pwm.sv
module sim_multi_edge_pwm;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] tbase_cnt;
    logic        tbase_zero;
    logic [127:0] cmp_lanes;
    logic [7:0]  act_cfg_a, act_cfg_b;
    logic [2:0]  used_a, used_b;
    logic        pwm_a, pwm_b;

    logic [15:0] cv [8];
    logic [1:0]  av [8];

    int checks = 0;
    int fails  = 0;
    logic sa = 1'b0, sb = 1'b0;

    typedef struct {
        logic  a;
        logic  b;
        string tag;
    } exp_t;
    exp_t sq[$];

    always #2 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 8; k++) cmp_lanes[k*16 +: 16] = cv[k];
        for (int j = 0; j < 4; j++) begin
            act_cfg_a[2*j +: 2] = av[j];
            act_cfg_b[2*j +: 2] = av[4+j];
        end
    end

    multi_edge_pwm u0 (
        .clk(clk), .rst_n(rst_n), .tbase_cnt(tbase_cnt), .tbase_zero(tbase_zero),
        .cmp_lanes(cmp_lanes), .act_cfg_a(act_cfg_a), .act_cfg_b(act_cfg_b),
        .used_a(used_a), .used_b(used_b), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    // Expected pin level after counter step c, folded from the period start.
    function automatic logic model_pin(logic start, int base, int used, int c);
        int   eff;
        int   prev;
        logic p;
        eff  = (used > 4) ? 4 : used;
        prev = 0;
        p    = start;
        for (int j = 0; j < eff; j++) begin
            int v;
            v = int'(cv[base+j]);
            if (v <= prev || v > c) break;
            case (av[base+j])
                2'b01:   p = 1'b0;
                2'b10:   p = 1'b1;
                2'b11:   p = ~p;
                default: ;
            endcase
            prev = v;
        end
        return p;
    endfunction

    // Driver: sweeps one period; zval is the counter value shown with the zero strobe.
    task automatic run_period(string tag, int prd, int zval);
        logic ea, eb;
        ea = sa;
        eb = sb;
        for (int c = 0; c < prd; c++) begin
            @(negedge clk);
            tbase_cnt  = (c == 0) ? 16'(zval) : 16'(c);
            tbase_zero = (c == 0);
            ea = model_pin(sa, 0, int'(used_a), c);
            eb = model_pin(sb, 4, int'(used_b), c);
            sq.push_back('{ea, eb, tag});
        end
        sa = ea;
        sb = eb;
        @(posedge clk);
        #1;
    endtask

    // Monitor: compare each result against the scoreboard.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sq.size() > 0) begin
                e = sq.pop_front();
                checks++;
                if (pwm_a !== e.a || pwm_b !== e.b) begin
                    fails++;
                    $display("FAIL %s: pwm_a,pwm_b=%b,%b expected %b,%b at t=%0t",
                             e.tag, pwm_a, pwm_b, e.a, e.b, $time);
                end
            end
        end
    end

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tbase_cnt = 16'd5; tbase_zero = 1'b0;
        used_a = 3'd3; used_b = 3'd2;
        // Lanes for pin A (R2 R3 R4 R5): edges at 5,10,20; lane 3 is disabled.
        cv[0] = 16'd5;  av[0] = 2'b10;
        cv[1] = 16'd10; av[1] = 2'b01;
        cv[2] = 16'd20; av[2] = 2'b11;
        cv[3] = 16'd25; av[3] = 2'b10;
        // Lanes for pin B: edges at 8,30; lanes 6,7 disabled.
        cv[4] = 16'd8;  av[4] = 2'b10;
        cv[5] = 16'd30; av[5] = 2'b01;
        cv[6] = 16'd12; av[6] = 2'b11;
        cv[7] = 16'd14; av[7] = 2'b11;
        repeat (3) @(negedge clk);
        checks++;  // R1 in reset, counter matching lane 0
        if (pwm_a !== 1'b0 || pwm_b !== 1'b0) begin
            fails++;
            $display("FAIL R1: pwm_a,pwm_b=%b,%b expected 0,0", pwm_a, pwm_b);
        end
        tbase_cnt = 16'd0;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;  // R1 after release
        if (pwm_a !== 1'b0 || pwm_b !== 1'b0) begin
            fails++;
            $display("FAIL R1: after release pwm_a,pwm_b=%b,%b expected 0,0", pwm_a, pwm_b);
        end

        run_period("R2 R3 R4 R5", 40, 0);
        run_period("R7 restart", 40, 0);

        // R6: pin A frozen, pin B count 7 acts as 4.
        used_a = 3'd0; used_b = 3'd7;
        cv[0] = 16'd2; av[0] = 2'b11;
        cv[4] = 16'd3;  av[4] = 2'b11;
        cv[5] = 16'd6;  av[5] = 2'b11;
        cv[6] = 16'd9;  av[6] = 2'b11;
        cv[7] = 16'd12; av[7] = 2'b11;
        run_period("R6", 20, 0);

        // R7 lane 0 at zero never matches; R8 descending lanes stall pin B.
        used_a = 3'd2; used_b = 3'd3;
        cv[0] = 16'd0;  av[0] = 2'b01;
        cv[1] = 16'd7;  av[1] = 2'b01;
        cv[4] = 16'd15; av[4] = 2'b11;
        cv[5] = 16'd10; av[5] = 2'b11;
        cv[6] = 16'd18; av[6] = 2'b11;
        run_period("R7 R8", 25, 0);

        // R3 all four codes on pin A, single lane on pin B.
        used_a = 3'd4; used_b = 3'd1;
        cv[0] = 16'd2; av[0] = 2'b01;
        cv[1] = 16'd4; av[1] = 2'b00;
        cv[2] = 16'd6; av[2] = 2'b10;
        cv[3] = 16'd8; av[3] = 2'b11;
        cv[4] = 16'd1; av[4] = 2'b10;
        run_period("R3 codes", 12, 0);

        // R7: counter equals the pending lane during the zero strobe.
        used_a = 3'd1; used_b = 3'd1;
        cv[0] = 16'd5; av[0] = 2'b11;
        cv[4] = 16'd5; av[4] = 2'b01;
        run_period("R7 priority", 10, 5);
        run_period("R7 priority", 10, 5);

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule